// File: doc/BRIEF.md
# Periodic Descriptor Frame-Match Gate

Once per frame this block decides which entries of a small periodic descriptor table may go out on the bus. Each entry has a kind, an active flag, a last flag and one 8-bit schedule byte. For an interrupt-kind entry, the schedule byte splits into two fields: a 5-bit start offset and a 3-bit polling-rate code. The entry is eligible when the running frame number and the start offset agree modulo the polling period. For an isochronous entry, the whole byte is an exact frame number, and the entry is eligible only in the frame whose low 8 bits equal it.

A last flag set on an isochronous entry closes the isochronous list. Isochronous entries placed after it in the table are ignored.

The result is an eligibility vector with one bit per table entry. The packet engine reads this vector. The vector is computed from the table and the frame number on the clock edge that samples the start-of-frame strobe, and it then holds until the next strobe.

Top module: `pfm_gate`

## Requirements
- R1: While `rst_n` is low, and after reset until the first strobe, `elig` is all zeros.
- R2: `elig` changes only on a rising clock edge that samples `sof` high. At that edge it takes the value computed from the inputs present at that edge. Table or frame changes without a strobe leave `elig` unchanged.
- R3: An entry whose `desc_active` bit is 0 is never eligible.
- R4: Entry i takes its kind from `desc_kind[2i+1:2i]`: 00 aperiodic, 01 interrupt, 10 isochronous, 11 reserved. Entries of kind aperiodic or reserved are never eligible. Entry i's schedule byte is `desc_sched[8i+7:8i]`.
- R5: An active isochronous entry that is not bounded by R7 is eligible exactly when its schedule byte equals `frame_num[7:0]`. Frame bits 10..8 play no part.
- R6: For an active interrupt entry, the start offset is byte bits [4:0] and the rate code r is byte bits [7:5]. The period is P = 2^r for r from 0 to 5, and P = 32 for r of 6 or 7. The entry is eligible exactly when `frame_num mod P` equals `start mod P`.
- R7: Let k be the lowest-indexed isochronous entry with its last flag set. Every isochronous entry with an index above k is never eligible. Entry k itself is still judged by R5.
- R8: A last flag on an interrupt, aperiodic or reserved entry has no effect on any entry's eligibility.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start-of-frame strobe, one cycle per frame |
| frame_num | input | 11 | Current frame number |
| desc_active | input | 8 | Per-entry active flag |
| desc_last | input | 8 | Per-entry last flag |
| desc_kind | input | 16 | Per-entry 2-bit kind code |
| desc_sched | input | 64 | Per-entry schedule byte |
| elig | output | 8 | Eligibility vector, bit i for entry i |

## Verification
The assertions assume two things: the frame number and the table carry no unknown bits in any cycle where the strobe is high, and the strobe and inputs are sampled cleanly at the clock edge. The bench drives every input on the falling edge. It keeps all of them at known values from reset onward and raises the strobe for exactly one cycle at a time. Between strobes it rewrites the table and the frame number to exercise the hold rule. This stays inside the assumptions, because the strobe is low whenever those rewrites happen.

// File: rtl/pfm_pkg.sv
// Shared encodings and field geometry for the periodic frame-match gate.
// Assumes an 8-bit schedule byte per descriptor.
package pfm_pkg;
    typedef enum logic [1:0] {
        KIND_APER = 2'b00,
        KIND_INTR = 2'b01,
        KIND_ISO  = 2'b10,
        KIND_RSVD = 2'b11
    } kind_e;

    localparam int SCHED_W  = 8;
    localparam int START_W  = 5;
    localparam int RATE_W   = SCHED_W - START_W;
    localparam int MAX_RATE = 5;
endpackage

// File: rtl/pfm_match.sv
// Per-entry match rule. Combinational: decides whether one descriptor
// qualifies in the frame given. Assumes frame_low holds the low byte of
// the frame number and blocked comes from the isochronous list bound.
module pfm_match
    import pfm_pkg::*;
(
    input  kind_e              kind,
    input  logic               active,
    input  logic               blocked,
    input  logic [SCHED_W-1:0] sched,
    input  logic [SCHED_W-1:0] frame_low,
    output logic               hit
);
    logic [RATE_W-1:0]  rate;
    logic [RATE_W-1:0]  rate_eff;
    logic [START_W-1:0] phase_mask;
    logic               intr_ok;
    logic               iso_ok;

    // Clamp the rate code and derive the low-bit mask of the polling period.
    always_comb begin
        rate       = sched[SCHED_W-1:START_W];
        rate_eff   = (rate > RATE_W'(MAX_RATE)) ? RATE_W'(MAX_RATE) : rate;
        phase_mask = ~({START_W{1'b1}} << rate_eff);
    end

    // Evaluate both rules and pick the one the kind selects.
    always_comb begin
        intr_ok = (((frame_low[START_W-1:0] ^ sched[START_W-1:0]) & phase_mask) == '0);
        iso_ok  = (sched == frame_low) && !blocked;
        unique case (kind)
            KIND_INTR: hit = active && intr_ok;
            KIND_ISO:  hit = active && iso_ok;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pfm_bound.sv
// Isochronous list bound. Entry i is blocked when any lower-indexed entry
// is an isochronous descriptor carrying the last flag. Assumes DEPTH >= 2.
module pfm_bound #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-2:0] iso_last,
    output logic [DEPTH-1:0] blocked
);
    assign blocked[0] = 1'b0;

    // Prefix-OR chain: once a closing entry is seen, everything after is blocked.
    for (genvar i = 1; i < DEPTH; i++) begin : g_chain
        assign blocked[i] = blocked[i-1] | iso_last[i-1];
    end
endmodule

// File: rtl/pfm_gate.sv
// Periodic descriptor frame-match gate. On each start-of-frame strobe, it
// registers the eligibility of every table entry and holds it until the next
// strobe. Assumes one strobe per frame and a table stable at the strobe edge.
module pfm_gate
    import pfm_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int FRAME_W = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sof,
    input  logic [FRAME_W-1:0]         frame_num,
    input  logic [DEPTH-1:0]           desc_active,
    input  logic [DEPTH-1:0]           desc_last,
    input  logic [2*DEPTH-1:0]         desc_kind,
    input  logic [SCHED_W*DEPTH-1:0]   desc_sched,
    output logic [DEPTH-1:0]           elig
);
    logic [SCHED_W-1:0] frame_low;
    logic [DEPTH-2:0]   iso_last;
    logic [DEPTH-1:0]   blocked;
    logic [DEPTH-1:0]   hit;

    assign frame_low = frame_num[SCHED_W-1:0];

    // Flag the entries that close the isochronous list.
    for (genvar i = 0; i < DEPTH - 1; i++) begin : g_last
        assign iso_last[i] = desc_last[i] && (kind_e'(desc_kind[2*i +: 2]) == KIND_ISO);
    end

    pfm_bound #(.DEPTH(DEPTH)) u_bound (
        .iso_last (iso_last),
        .blocked  (blocked)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        pfm_match u_match (
            .kind      (kind_e'(desc_kind[2*i +: 2])),
            .active    (desc_active[i]),
            .blocked   (blocked[i]),
            .sched     (desc_sched[SCHED_W*i +: SCHED_W]),
            .frame_low (frame_low),
            .hit       (hit[i])
        );
    end

    // Capture eligibility on the strobe, hold it for the rest of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elig <= '0;
        end else if (sof) begin
            elig <= hit;
        end
    end
endmodule

// File: rtl/pfm_gate_chk.sv
// Property checker for pfm_gate, attached through bind. Assumes known
// inputs whenever the strobe is high.
module pfm_gate_chk
    import pfm_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int FRAME_W = 11
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sof,
    input logic [FRAME_W-1:0]       frame_num,
    input logic [DEPTH-1:0]         desc_active,
    input logic [DEPTH-1:0]         desc_last,
    input logic [2*DEPTH-1:0]       desc_kind,
    input logic [SCHED_W*DEPTH-1:0] desc_sched,
    input logic [DEPTH-1:0]         elig
);
    logic [DEPTH-1:0] non_periodic;
    logic [DEPTH-1:0] iso_miss;

    // Entries that can never qualify by kind, and isochronous entries off-frame.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            non_periodic[i] = (desc_kind[2*i +: 2] == 2'b00) || (desc_kind[2*i +: 2] == 2'b11);
            iso_miss[i]     = (desc_kind[2*i +: 2] == 2'b10) &&
                              (desc_sched[SCHED_W*i +: SCHED_W] != frame_num[SCHED_W-1:0]);
        end
    end

    assert_known_inputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> !$isunknown({frame_num, desc_active, desc_last, desc_kind, desc_sched}));

    assert_hold_between_sof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(elig));

    assert_inactive_never_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> ((elig & ~$past(desc_active)) == '0));

    assert_kind_never_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> ((elig & $past(non_periodic)) == '0));

    assert_iso_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> ((elig & $past(iso_miss)) == '0));
endmodule

bind pfm_gate pfm_gate_chk #(.DEPTH(DEPTH), .FRAME_W(FRAME_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof         (sof),
    .frame_num   (frame_num),
    .desc_active (desc_active),
    .desc_last   (desc_last),
    .desc_kind   (desc_kind),
    .desc_sched  (desc_sched),
    .elig        (elig)
);

// File: tb/sim_pfm_gate.sv
module sim_pfm_gate;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int FW = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sof = 1'b0;
    logic [FW-1:0]    frame_num = '0;
    logic [DEPTH-1:0] desc_active = '0;
    logic [DEPTH-1:0] desc_last = '0;
    logic [15:0]      desc_kind = '0;
    logic [63:0]      desc_sched = '0;
    logic [DEPTH-1:0] elig;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfm_gate u0 (
        .clk(clk), .rst_n(rst_n), .sof(sof), .frame_num(frame_num),
        .desc_active(desc_active), .desc_last(desc_last),
        .desc_kind(desc_kind), .desc_sched(desc_sched), .elig(elig)
    );

    // Reference model, written from the requirements.
    function automatic logic [DEPTH-1:0] model();
        logic [DEPTH-1:0] r = '0;
        logic closed = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [1:0] k = desc_kind[2*i +: 2];
            logic [7:0] b = desc_sched[8*i +: 8];
            if (k == 2'b01) begin
                int rc = int'(b[7:5]);
                int p = (rc > 5) ? 32 : (1 << rc);
                r[i] = desc_active[i] && ((int'(frame_num) % p) == (int'(b[4:0]) % p));
            end else if (k == 2'b10) begin
                r[i] = desc_active[i] && !closed && (b == frame_num[7:0]);
                if (desc_last[i]) closed = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [DEPTH-1:0] exp);
        n_vec++;
        if (elig !== exp) begin
            n_bad++;
            $display("FAIL %s: elig=%b expected=%b", req, elig, exp);
        end
    endtask

    // Pulse the strobe with the current inputs, then check at the following falling edge.
    task automatic strobe(input string req);
        logic [DEPTH-1:0] e;
        e = model();
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        check(req, e);
    endtask

    task automatic set_entry(input int i, input logic [1:0] k, input logic a,
                             input logic l, input logic [7:0] b);
        desc_kind[2*i +: 2] = k;
        desc_active[i] = a;
        desc_last[i] = l;
        desc_sched[8*i +: 8] = b;
    endtask

    task automatic clear_table();
        desc_kind = '0; desc_active = '0; desc_last = '0; desc_sched = '0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: elig=%b expected=completion", elig);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [DEPTH-1:0] held;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        @(negedge clk);
        // R1: reset state, even with a strobe and a matching table present.
        set_entry(0, 2'b10, 1'b1, 1'b0, 8'h00);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        check("R1 during reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", '0);

        // R5: exact isochronous match; frame bits above 7 are irrelevant.
        clear_table();
        set_entry(0, 2'b10, 1'b1, 1'b0, 8'h37);
        set_entry(1, 2'b10, 1'b1, 1'b0, 8'h38);
        frame_num = 11'h737;
        strobe("R5 iso exact");
        check("R5 iso exact value", 8'b0000_0001);

        // R2: change everything without a strobe, output holds.
        frame_num = 11'h038;
        desc_active = '1;
        held = elig;
        @(negedge clk);
        @(negedge clk);
        check("R2 hold without sof", held);

        // R3: inactive entry never eligible.
        clear_table();
        set_entry(2, 2'b10, 1'b0, 1'b0, 8'h10);
        set_entry(3, 2'b01, 1'b0, 1'b0, 8'h00);
        frame_num = 11'h010;
        strobe("R3 inactive");

        // R4: aperiodic and reserved kinds never eligible.
        clear_table();
        set_entry(0, 2'b00, 1'b1, 1'b0, 8'h10);
        set_entry(1, 2'b11, 1'b1, 1'b0, 8'h10);
        set_entry(2, 2'b01, 1'b1, 1'b0, 8'h00);
        strobe("R4 kinds");

        // R6: rate codes 0..7 against a fixed start offset.
        for (int rc = 0; rc < 8; rc++) begin
            clear_table();
            set_entry(4, 2'b01, 1'b1, 1'b0, {3'(rc), 5'd13});
            frame_num = 11'd13 + 11'd64;
            strobe("R6 rate phase hit");
            frame_num = 11'd13 + 11'((1 << ((rc > 5) ? 5 : rc)) >> 1);
            strobe("R6 rate phase half");
        end

        // R7: the first closing iso entry bounds later iso entries only.
        clear_table();
        set_entry(0, 2'b10, 1'b1, 1'b0, 8'h55);
        set_entry(2, 2'b10, 1'b1, 1'b1, 8'h55);
        set_entry(3, 2'b01, 1'b1, 1'b0, 8'h15);
        set_entry(5, 2'b10, 1'b1, 1'b0, 8'h55);
        frame_num = 11'h155;
        strobe("R7 iso bound");
        check("R7 iso bound value", 8'b0000_1101);

        // R8: a last flag on interrupt and aperiodic entries changes nothing.
        clear_table();
        set_entry(1, 2'b01, 1'b1, 1'b1, 8'h00);
        set_entry(2, 2'b00, 1'b1, 1'b1, 8'h00);
        set_entry(3, 2'b11, 1'b1, 1'b1, 8'h00);
        set_entry(6, 2'b10, 1'b1, 1'b0, 8'h20);
        frame_num = 11'h020;
        strobe("R8 last on non-iso");
        check("R8 last on non-iso value", 8'b0100_0010);

        // Random mix covering R5, R6 and R7, each strobe followed by an R2 hold check.
        for (int it = 0; it < 400; it++) begin
            for (int i = 0; i < DEPTH; i++) begin
                set_entry(i, 2'($urandom_range(3, 0)), ($urandom_range(3, 0) != 0),
                          ($urandom_range(7, 0) == 0), 8'($urandom()));
            end
            frame_num = 11'($urandom());
            if ($urandom_range(1, 0) == 1) begin
                int j = $urandom_range(DEPTH - 1, 0);
                frame_num[7:0] = desc_sched[8*j +: 8];
            end
            strobe("R5 R6 R7 random");
            held = elig;
            frame_num = 11'($urandom());
            desc_sched = {$urandom(), $urandom()};
            @(negedge clk);
            check("R2 random hold", held);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule